// File: doc/BRIEF.md
# Dual-product mixing accumulator

This block forms the sum of two signed products, each with its own sign control, optionally adds a cascade word aligned to the upper part of the result, and folds the total into a running accumulator. It is used for image mixing, quadrature modulation, complex multiplication and filter tap summation. Two such blocks can be chained by feeding one block's result word into the other's cascade input. The operands arrive already time-aligned. Every stage is registered, and a new result leaves the block on every clock.

Each cycle presents four operands and a set of control bits that travel down the pipeline with them. The cascade word can instead take a short path: it joins the sum three clocks later than the operands it is added to. A 16-bit result port shows either the upper or the lower 16 bits of the 24-bit total. In its alternate mode the output stage freezes one total and shows its two overlapping halves on alternate clocks. A separate output-valid flag stands in for a bus enable.

Top module: `dpmix_acc`

## Requirements
- R1: The per-cycle term is (±a·b) + (±c·d). The operands are two's complement. neg_ab_i high subtracts a·b and neg_cd_i high subtracts c·d. All sums wrap modulo 2^ACC_W (ACC_W = 2·DATA_W) with no saturation.
- R2: With cas_ft_i low, the result for operands and controls presented in a cycle is on res_word_o after the sixth rising clock edge that follows.
- R3: With cas_ft_i low and cas_en_i high, cas_i from the same cycle is added with its LSB at accumulator bit CAS_SHIFT = ACC_W − CAS_W (bit 8 by default). With cas_en_i low, cas_i adds nothing.
- R4: With cas_ft_i high, the cascade word and its enable are taken from the cycle three clocks after the operands, instead of from the operands' own cycle.
- R5: acc_i low makes the item's term the new total and discards the previous total. acc_i high adds the term to the running total.
- R6: rnd_i high adds 1 at bit CAS_SHIFT−1 (bit 7 by default), but only when acc_i is low in the same cycle. With acc_i high, rnd_i has no effect.
- R7: msw_load_i high loads the item's total into the output stage and shows bits ACC_W−1..CAS_SHIFT (23..8) on res_word_o.
- R8: msw_load_i low leaves the stored total unchanged. res_word_o then alternates between the stored total's low word (bits CAS_W−1..0, i.e. 15..0) and its high word. The first low cycle after a load shows the low word.
- R9: res_vld_o equals res_oe_i in the same cycle, and res_oe_i has no effect on res_word_o.
- R10: A synchronous active-high rst_i clears every pipeline stage, the accumulator and the output stage to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| a_i | input | DATA_W | First multiplicand of product one |
| b_i | input | DATA_W | Second multiplicand of product one |
| c_i | input | DATA_W | First multiplicand of product two |
| d_i | input | DATA_W | Second multiplicand of product two |
| neg_ab_i | input | 1 | Subtract product one |
| neg_cd_i | input | 1 | Subtract product two |
| rnd_i | input | 1 | Half-LSB rounding at the start of a run |
| acc_i | input | 1 | Add to running total (low restarts it) |
| cas_ft_i | input | 1 | Short cascade path select |
| cas_en_i | input | 1 | Add the cascade word |
| msw_load_i | input | 1 | Load and show the high word (low: hold and alternate) |
| cas_i | input | CAS_W | Cascade word |
| res_oe_i | input | 1 | Output enable |
| res_word_o | output | CAS_W | Result word |
| res_vld_o | output | 1 | Output-valid flag |

## Verification
The bench builds the block with DATA_W = 4 and CAS_W = 6. This gives an 8-bit accumulator, a cascade weight of 4 and a rounding bit at position 1. At this size every pair of operand values can be swept under each sign combination, and every cascade word value can be tried with its enable on and off. The small accumulator also wraps often, so long accumulation runs, runs of held output cycles and mixes of the short cascade path with the aligned path all come up within a few thousand cycles. For every item the expected word comes from a plain arithmetic model of the requirements.

// File: rtl/dpmix_pkg.sv
package dpmix_pkg;

    // Number of product lanes summed per cycle.
    localparam int unsigned NUM_LANES = 2;

    // Register stages between the block inputs and the sum stage.
    localparam int unsigned FRONT_STAGES = 3;

    // Control bits that travel in step with the operands.
    typedef struct packed {
        logic rnd;
        logic acc;
        logic ft;
        logic cas_en;
        logic load;
    } mix_ctrl_t;

endpackage

// File: rtl/dpmix_prod.sv
// One product lane: operand register, product register, signed-term register.
module dpmix_prod #(
    parameter int unsigned DATA_W = 12
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [DATA_W-1:0]     x_i,
    input  logic [DATA_W-1:0]     y_i,
    input  logic                  neg_i,
    output logic [2*DATA_W-1:0]   term_o
);

    localparam int unsigned PROD_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic              neg_s1;
        logic [PROD_W-1:0] prod;
        logic              neg_s2;
        logic [PROD_W-1:0] term;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic signed [PROD_W-1:0] prod_full;

    always_comb begin
        prod_full   = $signed(st_q.x) * $signed(st_q.y);
        st_d        = st_q;
        st_d.x      = x_i;
        st_d.y      = y_i;
        st_d.neg_s1 = neg_i;
        st_d.prod   = prod_full;
        st_d.neg_s2 = st_q.neg_s1;
        st_d.term   = st_q.neg_s2 ? (~st_q.prod + PROD_W'(1)) : st_q.prod;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign term_o = st_q.term;

    AST_NEG_CANCELS: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.neg_s2 |=> (st_q.term + $past(st_q.prod)) == '0); // R1

    AST_POS_PASSES: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_q.neg_s2 |=> (st_q.term - $past(st_q.prod)) == '0); // R1

endmodule

// File: rtl/dpmix_accum.sv
// Sum stage (terms, cascade word, rounding) followed by the accumulator stage.
module dpmix_accum
    import dpmix_pkg::*;
#(
    parameter int unsigned ACC_W = 24,
    parameter int unsigned CAS_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ACC_W-1:0] term_ab_i,
    input  logic [ACC_W-1:0] term_cd_i,
    input  mix_ctrl_t        ctrl_i,
    input  logic [CAS_W-1:0] cas_pipe_i,
    input  logic [CAS_W-1:0] cas_port_i,
    input  logic             cas_en_port_i,
    output logic [ACC_W-1:0] total_o,
    output logic             load_o
);

    localparam int unsigned CAS_SHIFT = ACC_W - CAS_W;
    localparam int unsigned RND_BIT   = CAS_SHIFT - 1;

    typedef struct packed {
        logic [ACC_W-1:0] sum;
        logic             acc;
        logic             load_s4;
        logic [ACC_W-1:0] total;
        logic             load_s5;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [CAS_W-1:0] cas_sel;
    logic [ACC_W-1:0] cas_term;
    logic [ACC_W-1:0] rnd_term;

    always_comb begin
        if (ctrl_i.ft) begin
            cas_sel = cas_en_port_i ? cas_port_i : '0;
        end else begin
            cas_sel = ctrl_i.cas_en ? cas_pipe_i : '0;
        end
        cas_term          = {cas_sel, {CAS_SHIFT{1'b0}}};
        rnd_term          = '0;
        rnd_term[RND_BIT] = ctrl_i.rnd & ~ctrl_i.acc;

        st_d         = st_q;
        st_d.sum     = term_ab_i + term_cd_i + cas_term + rnd_term;
        st_d.acc     = ctrl_i.acc;
        st_d.load_s4 = ctrl_i.load;
        st_d.total   = st_q.acc ? (st_q.total + st_q.sum) : st_q.sum;
        st_d.load_s5 = st_q.load_s4;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign total_o = st_q.total;
    assign load_o  = st_q.load_s5;

    AST_RUN_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_q.acc |=> st_q.total == $past(st_q.sum)); // R5

    AST_RUN_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.acc |=> (st_q.total - $past(st_q.total)) == $past(st_q.sum)); // R5

endmodule

// File: rtl/dpmix_outreg.sv
// Output stage: a full-width snapshot of the total plus the word register.
module dpmix_outreg #(
    parameter int unsigned ACC_W = 24,
    parameter int unsigned OUT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ACC_W-1:0] total_i,
    input  logic             load_i,
    output logic [OUT_W-1:0] word_o
);

    typedef struct packed {
        logic [ACC_W-1:0] hold;
        logic [OUT_W-1:0] word;
        logic             phase;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.hold  = total_i;
            st_d.word  = total_i[ACC_W-1 -: OUT_W];
            st_d.phase = 1'b0;
        end else begin
            st_d.word  = st_q.phase ? st_q.hold[ACC_W-1 -: OUT_W]
                                    : st_q.hold[OUT_W-1:0];
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(st_q.hold)); // R8

    AST_LOAD_SHOWS_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> st_q.word == st_q.hold[ACC_W-1 -: OUT_W]); // R7

    AST_TOGGLE_LOW_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !st_q.phase) |=> st_q.word == st_q.hold[OUT_W-1:0]); // R8

endmodule

// File: rtl/dpmix_acc.sv
// Dual-product mixing accumulator, top level.
module dpmix_acc
    import dpmix_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned CAS_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] c_i,
    input  logic [DATA_W-1:0] d_i,
    input  logic              neg_ab_i,
    input  logic              neg_cd_i,
    input  logic              rnd_i,
    input  logic              acc_i,
    input  logic              cas_ft_i,
    input  logic              cas_en_i,
    input  logic              msw_load_i,
    input  logic [CAS_W-1:0]  cas_i,
    input  logic              res_oe_i,
    output logic [CAS_W-1:0]  res_word_o,
    output logic              res_vld_o
);

    localparam int unsigned ACC_W = 2 * DATA_W;
    localparam int unsigned OUT_W = CAS_W;
    localparam int unsigned LAST  = FRONT_STAGES - 1;

    // Control bits and the aligned cascade word, carried beside the lanes.
    typedef struct packed {
        mix_ctrl_t [FRONT_STAGES-1:0]            ctl;
        logic      [FRONT_STAGES-1:0][CAS_W-1:0] cas;
    } front_st_t;

    front_st_t st_d, st_q;

    always_comb begin
        st_d               = st_q;
        st_d.ctl[0].rnd    = rnd_i;
        st_d.ctl[0].acc    = acc_i;
        st_d.ctl[0].ft     = cas_ft_i;
        st_d.ctl[0].cas_en = cas_en_i;
        st_d.ctl[0].load   = msw_load_i;
        st_d.cas[0]        = cas_i;
        for (int s = 1; s < FRONT_STAGES; s++) begin
            st_d.ctl[s] = st_q.ctl[s-1];
            st_d.cas[s] = st_q.cas[s-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Product lanes.
    logic [NUM_LANES-1:0][DATA_W-1:0] lane_x;
    logic [NUM_LANES-1:0][DATA_W-1:0] lane_y;
    logic [NUM_LANES-1:0]             lane_neg;
    logic [NUM_LANES-1:0][ACC_W-1:0]  lane_term;

    assign lane_x   = {c_i, a_i};
    assign lane_y   = {d_i, b_i};
    assign lane_neg = {neg_cd_i, neg_ab_i};

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dpmix_prod #(
            .DATA_W (DATA_W)
        ) u_prod (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .x_i    (lane_x[g]),
            .y_i    (lane_y[g]),
            .neg_i  (lane_neg[g]),
            .term_o (lane_term[g])
        );
    end

    logic [ACC_W-1:0] total;
    logic             out_load;

    dpmix_accum #(
        .ACC_W (ACC_W),
        .CAS_W (CAS_W)
    ) u_accum (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .term_ab_i     (lane_term[0]),
        .term_cd_i     (lane_term[1]),
        .ctrl_i        (st_q.ctl[LAST]),
        .cas_pipe_i    (st_q.cas[LAST]),
        .cas_port_i    (cas_i),
        .cas_en_port_i (cas_en_i),
        .total_o       (total),
        .load_o        (out_load)
    );

    dpmix_outreg #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W)
    ) u_out (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .total_i (total),
        .load_i  (out_load),
        .word_o  (res_word_o)
    );

    assign res_vld_o = res_oe_i;

endmodule

// File: tb/tb_dpmix_acc.sv
`timescale 1ns/1ps
module tb_dpmix_acc;

    localparam int DW    = 4;
    localparam int CW    = 6;
    localparam int AW    = 2 * DW;
    localparam int SH    = AW - CW;
    localparam int AMASK = (1 << AW) - 1;
    localparam int OMASK = (1 << CW) - 1;
    localparam int PAD   = 5;
    localparam int MAXN  = 1100;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DW-1:0] a, b, c, d;
    logic neg_ab, neg_cd, rnd, accm, ft, cen, ld, oe;
    logic [CW-1:0] cas;
    logic [CW-1:0] word;
    logic vld;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int sa[MAXN], sb[MAXN], sc[MAXN], sd[MAXN], cs[MAXN];
    bit ng1[MAXN], ng2[MAXN], rn[MAXN], ac[MAXN], fth[MAXN], ce[MAXN], lw[MAXN], oen[MAXN];
    int ex[MAXN];
    logic [31:0] rs = 32'h1234_5678;

    always #2.5 clk = ~clk;

    dpmix_acc #(.DATA_W(DW), .CAS_W(CW)) dut (
        .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b), .c_i(c), .d_i(d),
        .neg_ab_i(neg_ab), .neg_cd_i(neg_cd), .rnd_i(rnd), .acc_i(accm),
        .cas_ft_i(ft), .cas_en_i(cen), .msw_load_i(ld), .cas_i(cas),
        .res_oe_i(oe), .res_word_o(word), .res_vld_o(vld)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT) begin
            errors = errors + 1;
            $display("FAIL R2 watchdog actual=%0d cycles expected<%0d", cyc, LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] step_rng(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic int sgn(input logic [DW-1:0] v);
        return int'($signed(v));
    endfunction

    // Fill stimulus item k (array index k+PAD) for a given pattern.
    task automatic gen(input int mode, input int k);
        int i;
        logic [31:0] r;
        logic [31:0] kk;
        i = k + PAD;
        rs = step_rng(rs);
        r = rs;
        kk = k;
        sa[i] = sgn(r[3:0]);  sb[i] = sgn(r[7:4]);
        sc[i] = sgn(r[11:8]); sd[i] = sgn(r[15:12]);
        cs[i] = int'(r[21:16]);
        ng1[i] = 0; ng2[i] = 0; rn[i] = 0; ac[i] = 0;
        fth[i] = 0; ce[i] = 0; lw[i] = 1; oen[i] = 1;
        case (mode)
            0: begin // R1 exhaustive a,b under each sign pair
                sa[i] = sgn(kk[3:0]); sb[i] = sgn(kk[7:4]);
                ng1[i] = kk[8]; ng2[i] = kk[9];
            end
            1: begin // R3 every cascade word, enable on and off
                cs[i] = int'(kk[5:0]); ce[i] = kk[6];
            end
            2: begin // R4 short cascade path mixed with aligned path
                fth[i] = r[22]; ce[i] = r[23];
            end
            3: begin // R5 accumulation runs of five
                ac[i] = (k % 5) != 0; ng1[i] = r[24]; ce[i] = r[25];
            end
            4: begin // R6 rounding with and without accumulate
                rn[i] = r[24]; ac[i] = r[25] & r[26]; ce[i] = r[27];
            end
            5: begin // R7/R8 runs of held output
                lw[i] = ((k / 3) % 3) != 0; ac[i] = r[24]; ce[i] = r[25];
            end
            default: begin // R2/R9 everything mixed
                ng1[i] = r[22]; ng2[i] = r[23]; rn[i] = r[24]; ac[i] = r[25];
                fth[i] = r[26]; ce[i] = r[27]; lw[i] = r[28] | r[29]; oen[i] = r[30];
            end
        endcase
    endtask

    // Arithmetic model of the requirements, one entry per item.
    task automatic build_expected(input int n);
        int hold, phase, word_m, accv, cv, s;
        hold = 0; phase = 0; accv = 0;
        for (int i = 0; i < PAD + n; i++) begin
            if (fth[i]) cv = ce[i+3] ? cs[i+3] : 0;
            else        cv = ce[i]   ? cs[i]   : 0;
            s = (ng1[i] ? -1 : 1) * sa[i] * sb[i]
              + (ng2[i] ? -1 : 1) * sc[i] * sd[i]
              + cv * (1 << SH)
              + ((rn[i] && !ac[i]) ? (1 << (SH - 1)) : 0);
            accv = ac[i] ? ((accv + s) & AMASK) : (s & AMASK);
            if (lw[i]) begin
                hold = accv;
                word_m = (hold >> SH) & OMASK;
                phase = 0;
            end else begin
                word_m = phase ? ((hold >> SH) & OMASK) : (hold & OMASK);
                phase = 1 - phase;
            end
            ex[i] = word_m;
        end
    endtask

    task automatic drive(input int i);
        a = DW'(sa[i]); b = DW'(sb[i]); c = DW'(sc[i]); d = DW'(sd[i]);
        neg_ab = ng1[i]; neg_cd = ng2[i]; rnd = rn[i]; accm = ac[i];
        ft = fth[i]; cen = ce[i]; ld = lw[i]; cas = CW'(cs[i]); oe = oen[i];
    endtask

    task automatic run_mode(input int mode, input int n, input string tag);
        string t;
        for (int i = 0; i < MAXN; i++) begin
            sa[i] = 0; sb[i] = 0; sc[i] = 0; sd[i] = 0; cs[i] = 0;
            ng1[i] = 0; ng2[i] = 0; rn[i] = 0; ac[i] = 0;
            fth[i] = 0; ce[i] = 0; lw[i] = 0; oen[i] = 1;
        end
        for (int k = 0; k < n; k++) gen(mode, k);
        build_expected(n);
        // Reset with live inputs: output must read zero (R10).
        @(negedge clk);
        rst = 1'b1;
        drive(PAD + 1);
        repeat (3) @(negedge clk);
        check("R10 reset word", int'(word), 0);
        rst = 1'b0;
        drive(PAD);
        for (int j = 1; j <= n + 6; j++) begin
            @(negedge clk);
            if (j < 6) check("R10 word before first result", int'(word), 0);
            if (j >= 6 && (j - 6) < n) begin
                t = tag;
                if (mode == 5) t = lw[j - 6 + PAD] ? "R7 high word" : "R8 toggle";
                check(t, int'(word), ex[j - 6 + PAD]);
            end
            check("R9 valid flag", int'(vld), int'(oe));
            drive(PAD + j);
        end
    endtask

    initial begin
        a = '0; b = '0; c = '0; d = '0; cas = '0;
        neg_ab = 0; neg_cd = 0; rnd = 0; accm = 0; ft = 0; cen = 0; ld = 0; oe = 0;
        repeat (3) @(negedge clk);
        check("R10 initial reset word", int'(word), 0);
        run_mode(0, 1024, "R1 signed products");
        run_mode(1, 256,  "R3 cascade weight");
        run_mode(2, 512,  "R4 short cascade path");
        run_mode(3, 512,  "R5 accumulate");
        run_mode(4, 512,  "R6 rounding");
        run_mode(5, 512,  "R8 toggle");
        run_mode(6, 1024, "R2 latency mixed");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule